// File: doc/BRIEF.md
# Configurable Interrupt Control Register

This block is one 8-bit control and status register that conditions a single interrupt line coming from a peripheral. Software writes the register to pick the input polarity, edge or level sensitivity, an enable and a 3-bit request level. The block resynchronizes the raw line into the local clock and applies the selected polarity. Depending on the mode, it either follows the line or latches active edges until software clears them.

The qualified pending state reads back as a status bit. A 3-bit level output carries the programmed level while a request is pending. It is zero when nothing is pending or when the programmed level is zero. The CPU side is a single-register port: a write strobe with 8-bit write data, and read data that is always valid.

Bit layout of the register, from bit 7 down to bit 0: `pol` (7), `edge_mode` (6), `pend` (5, read-only), `en` (4), `clr` (3, write-only, reads 0), `lvl` (2:0).

Top module: `irq_ctrl_reg`

## Requirements
- R1: After an active-low reset, `rd_data` reads 8'h00 and `irq_level` is 3'b000.
- R2: A write stores bits 7, 6, 4 and 2:0 of `wr_data`, and they read back from the next cycle on. Bit 3 always reads 0. Bit 5 cannot be set by a write; for example, writing 8'hFF with the pin low reads back 8'hD7.
- R3: In level mode (bit 6 = 0), bit 5 becomes (`irq_pin` XOR `pol`) AND `en`, three clock edges after the pin changes, and it keeps following the pin.
- R4: In edge mode (bit 6 = 1) with `en`=1, an active edge sets bit 5 three clock edges after the pin changes. For `pol`=0 the active edge is rising; for `pol`=1 it is falling. Bit 5 stays set after the pin returns. The opposite edge never sets it.
- R5: In edge mode, an active edge that arrives while `en`=0 is not recorded. Bit 5 stays 0, including after `en` is set later.
- R6: A write with bit 3 = 1 that leaves or puts the block in edge mode clears bit 5 from the next cycle on. In level mode the same write has no effect on bit 5.
- R7: In edge mode, a write that flips `pol` and also sets bit 3 leaves bit 5 at 0, even though the polarity flip reverses the adjusted input. The same flip written without bit 3 raises bit 5.
- R8: `irq_level` equals `lvl` while bit 5 is 1 and `lvl` is not 0. Otherwise it is 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 8 | Write data in the register layout |
| rd_data | output | 8 | Current register contents, with the pending bit and clear bit reading as described |
| irq_pin | input | 1 | Raw, asynchronous interrupt line from the peripheral |
| irq_level | output | 3 | Requested interrupt level, 0 when no request |

## Verification
In level mode, the bench sweeps every combination of polarity, enable and pin value. This separates a wrong XOR sense from a missing enable gate. In edge mode, it drives active and inactive transitions for both polarities, and also an active transition while the interrupt is disabled. These patterns separate true edge detection from level following, and sticky latching from transient flags. The level output is swept over all eight level codes to catch a zero-level leak or a bit mix-up. Paired polarity flips, written with and without the clear bit, show that the clear suppresses exactly the false edge the flip creates.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int REG_W   = 8;
    localparam int LVL_W   = 3;

    localparam int BIT_POL  = 7;
    localparam int BIT_EDGE = 6;
    localparam int BIT_PEND = 5;
    localparam int BIT_EN   = 4;
    localparam int BIT_CLR  = 3;

    typedef struct packed {
        logic             pol;
        logic             edge_mode;
        logic             en;
        logic [LVL_W-1:0] lvl;
    } cfg_t;

    typedef struct packed {
        logic prev;
        logic pend;
    } det_t;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = din;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/irq_detect.sv
module irq_detect
    import irq_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic pol_cur,
    input  logic pol_next,
    input  logic edge_next,
    input  logic en_next,
    input  logic clr_load,
    output logic pend
);

    det_t st_d, st_q;
    logic adj;
    logic active_edge;

    always_comb begin
        adj         = sync_in ^ pol_cur;
        active_edge = adj & ~st_q.prev;
        st_d        = st_q;

        // A clearing write reloads the history with the new polarity,
        // so a polarity flip in the same write cannot look like an edge.
        if (clr_load) st_d.prev = sync_in ^ pol_next;
        else          st_d.prev = adj;

        if (!edge_next) begin
            st_d.pend = adj & en_next;
        end else if (clr_load) begin
            st_d.pend = 1'b0;
        end else begin
            st_d.pend = st_q.pend | (active_edge & en_next);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;

endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
    import irq_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             irq_pin,
    output logic [LVL_W-1:0] irq_level
);

    cfg_t cfg_d, cfg_q;
    logic pin_sync;
    logic pend;
    logic clr_load;

    irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (irq_pin),
        .dout  (pin_sync)
    );

    always_comb begin
        cfg_d    = cfg_q;
        clr_load = wr_en & wr_data[BIT_CLR];
        if (wr_en) begin
            cfg_d.pol       = wr_data[BIT_POL];
            cfg_d.edge_mode = wr_data[BIT_EDGE];
            cfg_d.en        = wr_data[BIT_EN];
            cfg_d.lvl       = wr_data[LVL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    irq_detect u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_in   (pin_sync),
        .pol_cur   (cfg_q.pol),
        .pol_next  (cfg_d.pol),
        .edge_next (cfg_d.edge_mode),
        .en_next   (cfg_d.en),
        .clr_load  (clr_load),
        .pend      (pend)
    );

    always_comb begin
        rd_data              = '0;
        rd_data[BIT_POL]     = cfg_q.pol;
        rd_data[BIT_EDGE]    = cfg_q.edge_mode;
        rd_data[BIT_PEND]    = pend;
        rd_data[BIT_EN]      = cfg_q.en;
        rd_data[LVL_W-1:0]   = cfg_q.lvl;
        irq_level            = (pend && cfg_q.lvl != '0) ? cfg_q.lvl : '0;
    end

endmodule

// File: rtl/irq_ctrl_reg_chk.sv
module irq_ctrl_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic [2:0] irq_level
);

    AST_IDLE_LEVEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[5] |-> irq_level == 3'b000); // R8

    AST_LEVEL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[5] && rd_data[2:0] != 3'b000) |-> irq_level == rd_data[2:0]); // R8

    AST_WRITE_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[7:6] == $past(wr_data[7:6]) && rd_data[4] == $past(wr_data[4])
                   && rd_data[2:0] == $past(wr_data[2:0]) && !rd_data[3])); // R2

    AST_EDGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[3] && wr_data[6]) |=> !rd_data[5]); // R6

    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[6] && rd_data[5] && !wr_en) |=> rd_data[5]); // R4

    AST_EDGE_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[6] && !rd_data[5] && !rd_data[4] && !wr_en) |=> !rd_data[5]); // R5

    AST_LEVEL_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[6] && !rd_data[4] && !wr_en) |=> !rd_data[5]); // R3

endmodule

bind irq_ctrl_reg irq_ctrl_reg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .irq_level (irq_level)
);

// File: tb/irq_ctrl_reg_test.sv
module irq_ctrl_reg_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq_pin = 1'b0;
    logic [2:0] irq_level;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_ctrl_reg uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .irq_pin   (irq_pin),
        .irq_level (irq_level)
    );

    function automatic logic [7:0] cfg(input logic pol, input logic edg,
                                       input logic en, input logic clr,
                                       input logic [2:0] lvl);
        return {pol, edg, 1'b0, en, clr, lvl};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = 8'h00;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "rd_data", rd_data, 8'h00);
        check("R1", "irq_level", {5'b0, irq_level}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 field storage, clear reads 0, status not writable
        reg_write(8'hFF);
        check("R2", "write FF", rd_data, 8'hD7);
        reg_write(8'h00);
        check("R2", "write 00", rd_data, 8'h00);

        // R3 level mode sweep
        for (int p = 0; p < 2; p++) begin
            for (int e = 0; e < 2; e++) begin
                for (int v = 0; v < 2; v++) begin
                    logic exp;
                    reg_write(cfg(p[0], 1'b0, e[0], 1'b0, 3'd5));
                    irq_pin = v[0];
                    settle();
                    exp = (v[0] ^ p[0]) & e[0];
                    check("R3", "level pend", {7'b0, rd_data[5]}, {7'b0, exp});
                    check("R3", "level out", {5'b0, irq_level}, exp ? 8'h05 : 8'h00);
                end
            end
        end

        // R6 clear has no effect in level mode
        irq_pin = 1'b1;
        reg_write(cfg(1'b0, 1'b0, 1'b1, 1'b0, 3'd2));
        settle();
        reg_write(cfg(1'b0, 1'b0, 1'b1, 1'b1, 3'd2));
        check("R6", "level clr ignored", {7'b0, rd_data[5]}, 8'h01);

        // R8 level code sweep with a pending request
        for (int l = 0; l < 8; l++) begin
            reg_write(cfg(1'b0, 1'b0, 1'b1, 1'b0, l[2:0]));
            check("R8", "irq_level", {5'b0, irq_level}, {5'b0, l[2:0]});
        end
        irq_pin = 1'b0;
        settle();
        check("R8", "no pend level", {5'b0, irq_level}, 8'h00);

        // R4 / R5 / R6 edge mode, both polarities
        for (int p = 0; p < 2; p++) begin
            irq_pin = p[0];
            settle();
            reg_write(cfg(p[0], 1'b1, 1'b1, 1'b1, 3'd3));
            settle();
            check("R6", "edge after clr", {7'b0, rd_data[5]}, 8'h00);
            irq_pin = ~p[0];
            settle();
            check("R4", "active edge", {7'b0, rd_data[5]}, 8'h01);
            check("R4", "edge level out", {5'b0, irq_level}, 8'h03);
            irq_pin = p[0];
            settle();
            check("R4", "sticky", {7'b0, rd_data[5]}, 8'h01);
            reg_write(cfg(p[0], 1'b1, 1'b1, 1'b1, 3'd3));
            check("R6", "edge clr", {7'b0, rd_data[5]}, 8'h00);
            reg_write(cfg(p[0], 1'b1, 1'b0, 1'b1, 3'd3));
            irq_pin = ~p[0];
            settle();
            check("R5", "disabled edge", {7'b0, rd_data[5]}, 8'h00);
            reg_write(cfg(p[0], 1'b1, 1'b1, 1'b0, 3'd3));
            settle();
            check("R5", "after enable", {7'b0, rd_data[5]}, 8'h00);
            irq_pin = p[0];
            settle();
            check("R4", "inactive edge", {7'b0, rd_data[5]}, 8'h00);
        end

        // R7 polarity flip with and without clear
        irq_pin = 1'b0;
        settle();
        reg_write(cfg(1'b0, 1'b1, 1'b1, 1'b1, 3'd3));
        settle();
        reg_write(cfg(1'b1, 1'b1, 1'b1, 1'b1, 3'd3));
        settle();
        check("R7", "flip with clr", {7'b0, rd_data[5]}, 8'h00);
        reg_write(cfg(1'b0, 1'b1, 1'b1, 1'b1, 3'd3));
        settle();
        reg_write(cfg(1'b1, 1'b1, 1'b1, 1'b0, 3'd3));
        settle();
        check("R7", "flip without clr", {7'b0, rd_data[5]}, 8'h01);

        done = 1'b1;
        finish_run();
    end

endmodule